// File: doc/BRIEF.md
# GPIO Pin Event Status and Notification

This block keeps the event state for one GPIO port. Every clock it looks at the level that is actually on each pin. That level may come from the pin's own output driver, from external logic, or from both. As a result, software can raise an event by driving an output-enabled pin. Each pin is configured separately: a mode bit picks edge or level detection, and a polarity bit picks rising/high or falling/low. Any event that is detected is latched in a sticky status bit.

Software reads and writes two registers through a small register port. The status register is cleared by writing 1 to a bit. The enable register is plain read/write. The notification output goes high when any pin has both its status bit and its enable bit set, and only while notification is routed to an interrupt target.

Two inputs describe the power state: one says whether main power is present, the other whether the block is active. When main power is absent, status is wiped for pins that drive main-powered loads and kept for pins on the standby domain. When the block is inactive and main power is also absent, the register port goes dead and the notification output is held low.

Top module: `gpio_evt_stat`

## Requirements
- R1: An edge-type pin (mode bit 0) sets its status bit on the clock edge that sees a transition in the polarity direction: a 0-to-1 change when its polarity bit is 1, and a 1-to-0 change when it is 0. The comparison is against the level seen at the previous clock edge. No edge is detected on the first clock edge after reset.
- R2: Writing to the status register (`reg_sel` = 0) clears each bit written as 1 and leaves each bit written as 0 unchanged. If a new event arrives on the same edge as a clear, the event wins.
- R3: A level-type pin (mode bit 1) sets its status bit on every clock edge while the pin is at its active level (high when polarity is 1, low when it is 0). A write-1 clear has no effect while that level persists. Once the level goes away, the bit stays set until it is cleared.
- R4: While `main_pwr` is 0, the status bit of every pin whose `load_main` bit is 1 is forced to 0 on each clock edge. Status bits of pins whose `load_main` bit is 0 are unaffected.
- R5: While `blk_active` and `main_pwr` are both 0, access is blocked. In that state `reg_rdata` reads 0, writes to either register are ignored, and `notify` is 0.
- R6: `notify` is 1 exactly when `route_en` is 1, access is not blocked, and at least one pin has both its status bit and its enable bit set.
- R7: The enable register (`reg_sel` = 1) is read/write and takes `reg_wdata` on the clock edge where `reg_we` is 1. `reg_rdata` shows the register selected by `reg_sel` without delay.
- R8: After reset, both the status register and the enable register are 0 and `notify` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NPIN | Actual level present on each pin |
| evt_lvl_mode | input | NPIN | Per-pin detection mode, 1 = level, 0 = edge |
| evt_pol | input | NPIN | Per-pin polarity, 1 = rising/high, 0 = falling/low |
| load_main | input | NPIN | Per-pin load domain, 1 = main-powered load |
| main_pwr | input | 1 | Main power present |
| blk_active | input | 1 | Block is active |
| route_en | input | 1 | Notification is routed to an interrupt target |
| reg_sel | input | 1 | Register select, 0 = status, 1 = enable |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | NPIN | Write data |
| reg_rdata | output | NPIN | Read data of the selected register |
| notify | output | 1 | Notification output |

## Verification
The bench builds the block with the default NPIN of 8. At that width one port holds both domain flags side by side (upper four pins main-powered, lower four on standby), so a single power drop can be seen clearing some bits and keeping others. Eight lanes also leave room for edge and level pins of both polarities to run at the same time, which lets a clear on one bit race a fresh event on a neighbouring bit. After the directed steps, a random phase varies the pin levels, the configuration, the power state and the register writes, and every clock is compared against a behavioural model.

// File: rtl/gpio_evt_stat.sv
module gpio_evt_stat #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_lvl,
  input  logic [NPIN-1:0] evt_lvl_mode,
  input  logic [NPIN-1:0] evt_pol,
  input  logic [NPIN-1:0] load_main,
  input  logic            main_pwr,
  input  logic            blk_active,
  input  logic            route_en,
  input  logic            reg_sel,
  input  logic            reg_we,
  input  logic [NPIN-1:0] reg_wdata,
  output logic [NPIN-1:0] reg_rdata,
  output logic            notify
);

  logic [NPIN-1:0] stat_q, en_q, prev_q;
  logic            armed_q;
  logic            blocked;
  logic [NPIN-1:0] rise, fall, edge_hit, lvl_hit, set_v, clr_v, kill_v;

  assign blocked  = !blk_active && !main_pwr;
  assign rise     = pin_lvl & ~prev_q;
  assign fall     = ~pin_lvl & prev_q;
  assign edge_hit = armed_q ? ((rise & evt_pol) | (fall & ~evt_pol)) : '0;
  assign lvl_hit  = (pin_lvl & evt_pol) | (~pin_lvl & ~evt_pol);
  assign set_v    = (evt_lvl_mode & lvl_hit) | (~evt_lvl_mode & edge_hit);
  assign clr_v    = (reg_we && !reg_sel && !blocked) ? reg_wdata : '0;
  assign kill_v   = main_pwr ? '0 : load_main;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      en_q    <= '0;
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      stat_q  <= ((stat_q & ~clr_v) | set_v) & ~kill_v;
      if (reg_we && reg_sel && !blocked) en_q <= reg_wdata;
      prev_q  <= pin_lvl;
      armed_q <= 1'b1;
    end
  end

  assign reg_rdata = blocked ? '0 : (reg_sel ? en_q : stat_q);
  assign notify    = route_en && !blocked && |(stat_q & en_q);

  // R2: a status bit only drops through a clear or a power wipe
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_q) & ~$past(clr_v) & ~$past(kill_v)) & ~stat_q) == '0));

  // R3: an active level on a level-type pin keeps its bit set
  a_r3_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(evt_lvl_mode & lvl_hit) & ~$past(kill_v)) & ~stat_q) == '0));

  // R4: main power off wipes main-domain status
  a_r4_main_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    !main_pwr |=> ((stat_q & $past(load_main)) == '0));

  // R5: blocked access reads zero and notifies nothing
  a_r5_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> (reg_rdata == '0 && !notify));

  // R5: enable register frozen while blocked
  a_r5_en_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> $stable(en_q));

  // R6: notification needs routing and an enabled pending event
  a_r6_notify_cause: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> (route_en && (stat_q & en_q) != '0));

endmodule

// File: tb/tb_gpio_evt_stat.sv
module tb_gpio_evt_stat;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pin_lvl = 0, evt_lvl_mode = 0, evt_pol = 0, load_main = 0, reg_wdata = 0;
  logic main_pwr = 1, blk_active = 1, route_en = 1, reg_sel = 0, reg_we = 0;
  logic [N-1:0] reg_rdata;
  logic notify;

  gpio_evt_stat #(.NPIN(N)) dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [N-1:0] m_stat = 0, m_en = 0, m_prev = 0;
  logic m_armed = 0;

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat <= 0; m_en <= 0; m_prev <= 0; m_armed <= 0;
    end else begin
      logic blk;
      logic [N-1:0] nxt;
      blk = !blk_active && !main_pwr;
      nxt = m_stat;
      for (int i = 0; i < N; i++) begin
        logic hit;
        if (evt_lvl_mode[i]) hit = (pin_lvl[i] == evt_pol[i]);
        else hit = m_armed && (m_prev[i] != pin_lvl[i]) && (pin_lvl[i] == evt_pol[i]);
        if (reg_we && !reg_sel && !blk && reg_wdata[i]) nxt[i] = 1'b0;
        if (hit) nxt[i] = 1'b1;
        if (!main_pwr && load_main[i]) nxt[i] = 1'b0;
      end
      m_stat <= nxt;
      if (reg_we && reg_sel && !blk) m_en <= reg_wdata;
      m_prev <= pin_lvl;
      m_armed <= 1'b1;
    end
  end

  always @(negedge clk) if (rst_n) begin
    logic blk;
    logic [N-1:0] erd;
    blk = !blk_active && !main_pwr;
    erd = blk ? '0 : (reg_sel ? m_en : m_stat);
    chk("model R7 rdata", reg_rdata, erd);
    chk("model R6 notify", {{(N-1){1'b0}}, notify},
        {{(N-1){1'b0}}, route_en && !blk && ((m_stat & m_en) != 0)});
  end

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic wr(input logic sel, input logic [N-1:0] d);
    reg_sel = sel; reg_we = 1; reg_wdata = d;
    tick();
    reg_we = 0; reg_sel = 0; #1;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    load_main = 8'hF0; evt_pol = 8'hFF;
    repeat (3) @(posedge clk);
    #5 rst_n = 1; #1;
    chk("R8 status reset", reg_rdata, 8'h00);
    chk("R8 notify reset", {7'b0, notify}, 8'h00);
    wr(1, 8'hFF); reg_sel = 1; #1;
    chk("R7 enable write", reg_rdata, 8'hFF);
    reg_sel = 0;
    pin_lvl = 8'h01; tick(); #1;
    chk("R1 rising edge", reg_rdata, 8'h01);
    chk("R6 notify on event", {7'b0, notify}, 8'h01);
    wr(0, 8'h00);
    chk("R2 write zero no effect", reg_rdata, 8'h01);
    wr(0, 8'h01);
    chk("R2 write one clears", reg_rdata, 8'h00);
    evt_pol = 8'hFD;
    pin_lvl = 8'h03; tick(); #1;
    chk("R1 wrong direction ignored", reg_rdata, 8'h00);
    pin_lvl = 8'h01; tick(); #1;
    chk("R1 falling edge", reg_rdata, 8'h02);
    wr(0, 8'hFF);
    chk("R2 clear all", reg_rdata, 8'h00);
    evt_lvl_mode = 8'h04; pin_lvl = 8'h05; tick(); #1;
    chk("R3 level sets", reg_rdata, 8'h04);
    wr(0, 8'h04);
    chk("R3 clear blocked at active level", reg_rdata, 8'h04);
    pin_lvl = 8'h01; tick(); #1;
    chk("R3 stays after level gone", reg_rdata, 8'h04);
    wr(0, 8'h04);
    chk("R3 clear after release", reg_rdata, 8'h00);
    evt_lvl_mode = 8'h00;
    route_en = 0; pin_lvl = 8'h09; tick(); #1;
    chk("R6 unrouted no notify", {7'b0, notify}, 8'h00);
    route_en = 1; #1;
    chk("R6 routed notify", {7'b0, notify}, 8'h01);
    wr(1, 8'hF7);
    chk("R6 disabled pin no notify", {7'b0, notify}, 8'h00);
    wr(1, 8'hFF);
    pin_lvl = 8'h19; tick(); #1;
    chk("R1 second pin edge", reg_rdata, 8'h18);
    main_pwr = 0; tick(); #1;
    chk("R4 main-domain wiped", reg_rdata, 8'h08);
    blk_active = 0; #1;
    chk("R5 blocked read zero", reg_rdata, 8'h00);
    chk("R5 blocked notify low", {7'b0, notify}, 8'h00);
    wr(1, 8'h00);
    wr(0, 8'hFF);
    blk_active = 1; main_pwr = 1; #1;
    chk("R5 status write ignored", reg_rdata, 8'h08);
    reg_sel = 1; #1;
    chk("R5 enable write ignored", reg_rdata, 8'hFF);
    reg_sel = 0;
    for (int k = 0; k < 600; k++) begin
      pin_lvl = $urandom; reg_sel = $urandom; reg_wdata = $urandom;
      reg_we = ($urandom % 3) == 0; route_en = ($urandom % 8) != 0;
      main_pwr = ($urandom % 6) != 0; blk_active = ($urandom % 4) != 0;
      if (k % 50 == 0) begin
        evt_lvl_mode = $urandom; evt_pol = $urandom; load_main = $urandom;
      end
      tick();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule